// File: doc/BRIEF.md
# Link-On Wake Request Generator

This block drives the wake line that a physical-layer device uses to bring a sleeping link-layer controller back to full power. The link layer counts as asleep when its sensed power status is low or when the link-control bit is cleared. A wake event is either a link-on packet addressed to this node or, when interrupt wake-up is enabled, a pending PHY interrupt. A wake event that arrives while the link layer is asleep sets a request. The request stays set until the link layer is fully awake. A bus reset also drops the request, unless an enabled interrupt is still pending.

While the request is set, the wake line toggles as a square wave rather than holding a steady level. The wave always begins on its high half. When the device comes out of reset with a power class from 0 to 4, the line also runs the same square wave for a fixed power-up window, counted in clock cycles. The window stops early if the link layer wakes during it.

Packet decoding and the interrupt sources are outside this block. It receives a one-cycle packet-hit strobe and a level for the pending interrupt.

Top module: `linkon_wake_gen`

## Requirements
- R1: While the wake request or the power-up window is active, `linkon_out` is high for HALF_CYC cycles, then low for HALF_CYC cycles, and repeats this pattern. It is high in the first active cycle.
- R2: `linkon_out` is 0 during reset and in every cycle in which neither the request nor the power-up window is active.
- R3: A `pkt_hit` pulse sampled while the link layer is asleep sets the request from the next cycle on. The request then holds after the pulse ends.
- R4: `irq_pend` counts as a wake event only when `irq_wake_en` is 1. With `irq_wake_en` at 0, it neither sets the request nor keeps it through a bus reset.
- R5: The link layer is asleep when `lps_active` is 0 or `link_ctrl` is 0. Wake events sampled while both inputs are 1 are ignored.
- R6: A set request clears in the cycle after both `lps_active` and `link_ctrl` are sampled as 1.
- R7: `bus_reset` sampled as 1 clears the request. The one exception is when `irq_pend` and `irq_wake_en` are both 1, in which case the request is set. A `pkt_hit` in the same cycle does not keep the request.
- R8: In the first cycle after reset is released, a `power_class` of 0 to 4 with the link layer asleep starts a power-up window of exactly PWRUP_CYC cycles. Classes 5 to 7 start no window, and the window never restarts without another reset.
- R9: An active power-up window ends in the cycle after the link layer is sampled awake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low (power cycle) |
| lps_active | input | 1 | Sensed link power status, 1 = active |
| link_ctrl | input | 1 | Link-control bit |
| pkt_hit | input | 1 | One-cycle strobe: link-on packet for this node received |
| irq_pend | input | 1 | PHY interrupt condition pending (level) |
| irq_wake_en | input | 1 | Allow a pending interrupt to act as a wake event |
| bus_reset | input | 1 | One-cycle strobe: bus reset occurred |
| power_class | input | 3 | Node power class, sampled on reset exit |
| linkon_out | output | 1 | Square-wave wake output to the link layer |

## Verification
The bench sweeps all eight power classes across a full power-up window. A design that used the wrong class threshold, or that was off by one in the window length, would show the wave running for the wrong number of cycles. It then drives all 64 combinations of status, control bit, interrupt, enable, packet strobe and bus reset, starting once from a set request and once from a clear one. This catches a reset exception that ignores the enable, a packet that survives a bus reset, and events that are latched while the link layer is awake. Every cycle is compared against an arithmetic model of the wave phase, so a wave that starts low or has the wrong half period fails at once. A separate case wakes the link layer in the middle of the power-up window, and checks that the window stops instead of running to its end.

// File: rtl/linkon_pkg.sv
// Shared types and the power-class rule for the link-on wake generator.
package linkon_pkg;

    typedef logic [2:0] pwr_class_t;

    // Highest power class that still receives a power-up wake window.
    localparam pwr_class_t BOOT_CLASS_MAX = 3'd4;

    // True when the given class should receive the power-up window.
    function automatic logic class_wants_boot(input pwr_class_t cls);
        return cls <= BOOT_CLASS_MAX;
    endfunction

endpackage

// File: rtl/linkon_req_latch.sv
// Wake request latch.
// Sets on a wake event seen while the link layer is asleep. Clears when the
// link layer is awake. A bus reset clears it unless an enabled interrupt is
// pending. Assumes pkt_hit and bus_reset are one-cycle strobes.
module linkon_req_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic link_asleep,
    input  logic pkt_hit,
    input  logic irq_pend,
    input  logic irq_wake_en,
    input  logic bus_reset,
    output logic req
);

    logic irq_event;

    // An interrupt counts only when wake-up by interrupt is enabled.
    assign irq_event = irq_pend & irq_wake_en;

    // Request state: awake clears, bus reset overrides, events set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req <= 1'b0;
        end else if (!link_asleep) begin
            req <= 1'b0;
        end else if (bus_reset) begin
            req <= irq_event;
        end else if (pkt_hit || irq_event) begin
            req <= 1'b1;
        end
    end

    AST_REQ_CLR_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !link_asleep |=> !req); // R6

    AST_REQ_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!req && !pkt_hit && !(irq_pend && irq_wake_en)) |=> !req); // R4

    AST_REQ_BUSRST_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reset && !(irq_pend && irq_wake_en)) |=> !req); // R7

    AST_REQ_SET_ON_PKT: assert property (@(posedge clk) disable iff (!rst_n)
        (link_asleep && pkt_hit && !bus_reset) |=> req); // R3

endmodule

// File: rtl/linkon_pwrup_timer.sv
// Power-up wake window.
// On the first cycle after reset, the window opens if the power class is low
// enough and the link layer is asleep. It then lasts PWRUP_CYC cycles, or
// less if the link layer wakes. Assumes PWRUP_CYC >= 1.
module linkon_pwrup_timer
    import linkon_pkg::*;
#(
    parameter int PWRUP_CYC = 41750
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       link_asleep,
    input  pwr_class_t power_class,
    output logic       pwr_on
);

    localparam int CW = (PWRUP_CYC > 1) ? $clog2(PWRUP_CYC) : 1;
    localparam logic [CW-1:0] LOAD_VAL = CW'(PWRUP_CYC - 1);

    logic          boot;
    logic [CW-1:0] left_cnt;

    // Boot flag marks the single cycle right after reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot <= 1'b1;
        end else begin
            boot <= 1'b0;
        end
    end

    // Window state and down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_on   <= 1'b0;
            left_cnt <= '0;
        end else if (boot) begin
            pwr_on   <= class_wants_boot(power_class) && link_asleep;
            left_cnt <= LOAD_VAL;
        end else if (pwr_on) begin
            if (!link_asleep || left_cnt == '0) begin
                pwr_on <= 1'b0;
            end else begin
                left_cnt <= left_cnt - 1'b1;
            end
        end
    end

    AST_PWR_CLASS_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (boot && power_class > BOOT_CLASS_MAX) |=> !pwr_on); // R8

    AST_PWR_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (!boot && !pwr_on) |=> !pwr_on); // R8

    AST_PWR_WINDOW_END: assert property (@(posedge clk) disable iff (!rst_n)
        (!boot && pwr_on && left_cnt == '0) |=> !pwr_on); // R8

    AST_PWR_EARLY_END: assert property (@(posedge clk) disable iff (!rst_n)
        (!boot && !link_asleep) |=> !pwr_on); // R9

endmodule

// File: rtl/linkon_sq_divider.sv
// Square-wave divider.
// While enabled, the output is high for HALF_CYC cycles and then low for
// HALF_CYC cycles, starting on the high half. It is held low when disabled.
// Assumes HALF_CYC >= 1.
module linkon_sq_divider #(
    parameter int HALF_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic wave_out
);

    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] half_cnt;
    logic          phase;

    // Phase counter: cleared with phase high while idle, toggles each half.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            half_cnt <= '0;
            phase    <= 1'b1;
        end else if (half_cnt == LAST) begin
            half_cnt <= '0;
            phase    <= ~phase;
        end else begin
            half_cnt <= half_cnt + 1'b1;
        end
    end

    // Output gated by the enable so idle is always low.
    assign wave_out = en & phase;

    AST_SQ_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |-> wave_out); // R1

    AST_SQ_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        half_cnt <= LAST); // R1

    AST_SQ_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && half_cnt == LAST) |=> (!en || phase != $past(phase))); // R1

endmodule

// File: rtl/linkon_wake_gen.sv
// Link-on wake generator (top).
// Decides whether the link layer is asleep, then combines the wake request
// latch and the power-up window. The square-wave divider runs whenever
// either of them is active. Assumes all inputs are synchronous to clk.
module linkon_wake_gen
    import linkon_pkg::*;
#(
    parameter int HALF_CYC  = 8,
    parameter int PWRUP_CYC = 41750
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lps_active,
    input  logic       link_ctrl,
    input  logic       pkt_hit,
    input  logic       irq_pend,
    input  logic       irq_wake_en,
    input  logic       bus_reset,
    input  logic [2:0] power_class,
    output logic       linkon_out
);

    logic link_asleep;
    logic req;
    logic pwr_on;
    logic wake_en;

    // Link layer asleep when the status is low or the control bit is clear.
    assign link_asleep = !lps_active || !link_ctrl;
    // Wave runs while either source wants the link layer awake.
    assign wake_en     = req | pwr_on;

    linkon_req_latch u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .link_asleep(link_asleep),
        .pkt_hit    (pkt_hit),
        .irq_pend   (irq_pend),
        .irq_wake_en(irq_wake_en),
        .bus_reset  (bus_reset),
        .req        (req)
    );

    linkon_pwrup_timer #(.PWRUP_CYC(PWRUP_CYC)) u_pwr (
        .clk        (clk),
        .rst_n      (rst_n),
        .link_asleep(link_asleep),
        .power_class(pwr_class_t'(power_class)),
        .pwr_on     (pwr_on)
    );

    linkon_sq_divider #(.HALF_CYC(HALF_CYC)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (wake_en),
        .wave_out(linkon_out)
    );

    AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!req && !pwr_on) |-> !linkon_out); // R2

    AST_AWAKE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (lps_active && link_ctrl) |=> !linkon_out); // R5

endmodule

// File: tb/tb_linkon_wake_gen.sv
`timescale 1ns/1ps
module tb_linkon_wake_gen;

    localparam int HALF = 3;
    localparam int PWR  = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lps_active = 1'b0;
    logic       link_ctrl = 1'b0;
    logic       pkt_hit = 1'b0;
    logic       irq_pend = 1'b0;
    logic       irq_wake_en = 1'b0;
    logic       bus_reset = 1'b0;
    logic [2:0] power_class = 3'd7;
    logic       linkon_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Reference model state
    bit m_boot = 1'b1;
    bit m_req = 1'b0;
    int m_left = 0;
    bit m_en_prev = 1'b0;
    int m_t = 0;
    bit m_exp = 1'b0;

    always #2 clk = ~clk;

    linkon_wake_gen #(.HALF_CYC(HALF), .PWRUP_CYC(PWR)) dut (
        .clk(clk), .rst_n(rst_n), .lps_active(lps_active), .link_ctrl(link_ctrl),
        .pkt_hit(pkt_hit), .irq_pend(irq_pend), .irq_wake_en(irq_wake_en),
        .bus_reset(bus_reset), .power_class(power_class), .linkon_out(linkon_out)
    );

    // Advance one clock, update model at the edge, compare half a cycle later.
    task automatic step(input string tag);
        bit asleep, irqev, en;
        @(posedge clk);
        if (!rst_n) begin
            m_boot = 1'b1; m_req = 1'b0; m_left = 0; m_en_prev = 1'b0; m_exp = 1'b0;
        end else begin
            asleep = !lps_active || !link_ctrl;
            irqev  = irq_pend && irq_wake_en;
            if (m_boot) begin
                m_left = (power_class <= 3'd4 && asleep) ? PWR : 0;
                m_boot = 1'b0;
            end else if (m_left > 0) begin
                m_left = asleep ? m_left - 1 : 0;
            end
            m_req = asleep && (bus_reset ? irqev : (m_req || pkt_hit || irqev));
            en = m_req || (m_left > 0);
            if (en) begin
                m_t = m_en_prev ? m_t + 1 : 0;
                m_exp = ((m_t / HALF) % 2) == 0;
            end else begin
                m_exp = 1'b0;
            end
            m_en_prev = en;
        end
        @(negedge clk);
        checks++;
        if (linkon_out !== m_exp) begin
            failures++;
            $display("FAIL %s t=%0t linkon_out=%b expected=%b", tag, $time, linkon_out, m_exp);
        end
    endtask

    task automatic do_reset(input logic [2:0] cls);
        power_class = cls;
        rst_n = 1'b0;
        step("R2 reset");
        step("R2 reset");
        rst_n = 1'b1;
    endtask

    task automatic idle_inputs();
        lps_active = 1'b0; link_ctrl = 1'b0; pkt_hit = 1'b0;
        irq_pend = 1'b0; irq_wake_en = 1'b0; bus_reset = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        // R8 R1 sweep over all power classes with the link layer asleep
        for (int c = 0; c < 8; c++) begin
            idle_inputs();
            do_reset(3'(c));
            for (int k = 0; k < PWR + 8; k++) step("R8 R1 power-up");
        end

        // R9 early end of the window
        idle_inputs();
        do_reset(3'd2);
        for (int k = 0; k < 6; k++) step("R9 window");
        lps_active = 1'b1; link_ctrl = 1'b1;
        for (int k = 0; k < 6; k++) step("R9 early end");

        // R3 R1 packet wake and long wave, then R6 clear
        idle_inputs();
        do_reset(3'd7);
        step("R2 idle");
        pkt_hit = 1'b1; step("R3 packet");
        pkt_hit = 1'b0;
        for (int k = 0; k < 14; k++) step("R3 R1 hold");
        lps_active = 1'b1; link_ctrl = 1'b1;
        for (int k = 0; k < 4; k++) step("R6 clear");

        // R5 status active but control bit clear still counts as asleep
        link_ctrl = 1'b0;
        pkt_hit = 1'b1; step("R5 ctrl clear");
        pkt_hit = 1'b0;
        for (int k = 0; k < 5; k++) step("R5 latched");
        link_ctrl = 1'b1; step("R6 clear");
        // R5 events while awake are ignored, checked after going back asleep
        pkt_hit = 1'b1; irq_pend = 1'b1; irq_wake_en = 1'b1; step("R5 awake");
        pkt_hit = 1'b0; irq_pend = 1'b0; irq_wake_en = 1'b0;
        lps_active = 1'b0;
        for (int k = 0; k < 4; k++) step("R5 ignored");

        // R4 interrupt gating
        irq_pend = 1'b1;
        for (int k = 0; k < 4; k++) step("R4 disabled");
        irq_wake_en = 1'b1;
        for (int k = 0; k < 5; k++) step("R4 enabled");
        // R7 bus reset with pending enabled interrupt keeps request
        bus_reset = 1'b1; step("R7 keep");
        bus_reset = 1'b0;
        for (int k = 0; k < 4; k++) step("R7 kept");
        irq_wake_en = 1'b0;
        bus_reset = 1'b1; pkt_hit = 1'b1; step("R7 clear");
        bus_reset = 1'b0; pkt_hit = 1'b0;
        for (int k = 0; k < 4; k++) step("R7 cleared");

        // Exhaustive: 64 input combinations from both request states
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < 64; i++) begin
                idle_inputs();
                if (p == 1) begin pkt_hit = 1'b1; end else begin bus_reset = 1'b1; end
                step("R3 R7 prepare");
                idle_inputs();
                {lps_active, link_ctrl, irq_pend, irq_wake_en, pkt_hit, bus_reset} = 6'(i);
                step("R3 R4 R5 R6 R7 combo");
                idle_inputs();
                for (int k = 0; k < 3; k++) step("R3 R4 R5 R6 R7 after");
                lps_active = 1'b1; link_ctrl = 1'b1;
                step("R6 settle");
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        #(4 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule